// File: doc/BRIEF.md
# Multidrop Receiver Wakeup Controller

This block sits beside a serial receiver on a line shared by several receivers. Software sets a wakeup-enable control bit when the traffic on the line is addressed to another node. The block then holds the receiver in standby. In standby, every receiver interrupt is masked, and received characters are not reported as available.

The block leaves standby under one of two conditions, picked by a wake-select input:
- **Idle line.** The line stays high for a run of consecutive bit times. The run is 10 bits for 8-bit characters and 11 bits for 9-bit characters.
- **Address mark.** A character arrives with its most significant bit set.

When standby ends, the wakeup-enable bit clears by itself. The character that caused an address-mark wakeup is delivered in the normal way.

Bit recovery is not part of this block. A front end supplies one sampled bit value per bit strobe. At the end of each character it supplies a character-complete strobe together with the character's MSB, which is bit 7 in 8-bit mode and bit 8 in 9-bit mode.

Top module: `mdrop_wake_ctrl`

## Requirements
- R1: After reset, standby_o is 0 and char_deliver_o is 0.
- R2: A cycle with ctrl_wr_i=1 loads ctrl_wake_en_i into standby_o on the next clock edge. Writing 1 enters standby and writing 0 leaves it. A write takes priority over any wake condition in the same cycle.
- R3: rx_irq_en_o equals rx_irq_en_i AND NOT standby_o in the same cycle.
- R4: In idle-line mode (wake_sel_i=0) with 8-bit characters (nine_bit_i=0), standby ends at the edge of the 10th consecutive bit strobe that samples 1. Nine such strobes do not end it.
- R5: In idle-line mode with 9-bit characters (nine_bit_i=1), standby ends at the 11th consecutive strobe that samples 1. Ten do not end it.
- R6: A bit strobe that samples 0 restarts the idle run from zero.
- R7: bit_val_i has no effect in cycles where bit_stb_i=0.
- R8: After standby is entered, an idle-line wakeup needs at least one strobe that samples 0 before the idle run. A line that was already idle when standby was entered does not wake the receiver, however long it stays high.
- R9: In address-mark mode (wake_sel_i=1), a character_done with char_msb_i=1 during standby clears standby_o and pulses char_deliver_o at the next edge.
- R10: During standby, a character that does not cause a wakeup raises no char_deliver_o and leaves standby_o at 1. This covers two cases: an MSB of 0 in address-mark mode, and any MSB in idle-line mode. In address-mark mode, idle runs never end standby.
- R11: Outside standby, each char_done_i pulse produces a one-cycle char_deliver_o pulse at the next edge, whatever char_msb_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Write strobe for the wakeup-enable bit |
| ctrl_wake_en_i | input | 1 | Value written to the wakeup-enable bit |
| wake_sel_i | input | 1 | 0: idle-line wakeup, 1: address-mark wakeup |
| nine_bit_i | input | 1 | 1: 9-bit characters, 0: 8-bit characters |
| rx_irq_en_i | input | 1 | Software receiver interrupt enable |
| bit_stb_i | input | 1 | One pulse per recovered bit time |
| bit_val_i | input | 1 | Sampled line value, valid with bit_stb_i |
| char_done_i | input | 1 | Character-complete pulse |
| char_msb_i | input | 1 | MSB of the completed character |
| standby_o | output | 1 | Standby state (wakeup-enable bit readback) |
| rx_irq_en_o | output | 1 | Receiver interrupt enable after standby gating |
| char_deliver_o | output | 1 | Pulse: completed character is to be reported full |

## Verification
Each output is due at a fixed point after the stimulus that drives it:
- standby_o changes one edge after the write or after the strobe or character that wakes the receiver.
- char_deliver_o is registered, so it appears one edge after char_done_i.
- rx_irq_en_o is combinational, so it follows its input and the current standby_o in the same cycle.

The bench drives each cycle's inputs at the falling edge. At that point it computes the post-edge value of all three outputs and queues it. A monitor samples one nanosecond after the next rising edge, so every comparison lands exactly on the cycle in which the result is due.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_ADDR = 1'b1
  } wake_sel_e;

  localparam int unsigned IDLE_LEN_8 = 10;
  localparam int unsigned IDLE_LEN_9 = 11;
endpackage

// File: rtl/mdw_idle_det.sv
module mdw_idle_det #(
  parameter int unsigned LEN8 = 10,
  parameter int unsigned LEN9 = 11,
  localparam int unsigned CW = $clog2(LEN9 + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic nine_bit_i,
  input  logic bit_stb_i,
  input  logic bit_val_i,
  output logic idle_hit_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;
  logic          armed_q;

  assign thr = nine_bit_i ? CW'(LEN9) : CW'(LEN8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (bit_stb_i) begin
      if (!bit_val_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (cnt_q < thr) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // run reaches threshold on this strobe; only after a 0 was seen
  assign idle_hit_o = bit_stb_i & bit_val_i & armed_q & ~clr_i &
                      (cnt_q >= thr - 1'b1);

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LEN9));
  p_zero_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && !bit_val_i && !clr_i) |=> (cnt_q == '0));
  p_no_strobe_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_stb_i && !clr_i) |=> $stable(cnt_q));
  p_arm_only_by_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(bit_stb_i && !bit_val_i));
endmodule

// File: rtl/mdw_char_gate.sv
module mdw_char_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic addr_mode_i,
  input  logic char_done_i,
  input  logic char_msb_i,
  output logic addr_hit_o,
  output logic deliver_o
);
  logic deliver_q;

  assign addr_hit_o = standby_i & addr_mode_i & char_done_i & char_msb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) deliver_q <= 1'b0;
    else         deliver_q <= char_done_i & (~standby_i | addr_hit_o);
  end

  assign deliver_o = deliver_q;

  p_deliver_needs_char_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_q |-> $past(char_done_i));
  p_standby_deliver_only_mark_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_q && $past(standby_i)) |-> $past(char_msb_i && addr_mode_i));
endmodule

// File: rtl/mdw_standby_reg.sv
module mdw_standby_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic idle_hit_i,
  input  logic addr_hit_i,
  input  logic addr_mode_i,
  output logic standby_o
);
  logic standby_q;
  logic wake;

  assign wake = addr_mode_i ? addr_hit_i : idle_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 standby_q <= 1'b0;
    else if (wr_i)               standby_q <= wdata_i;
    else if (standby_q && wake)  standby_q <= 1'b0;
  end

  assign standby_o = standby_q;

  p_write_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (standby_q == $past(wdata_i)));
  p_exit_has_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(standby_q) && !$past(wr_i)) |-> $past(wake));
  p_enter_only_by_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_q) |-> $past(wr_i && wdata_i));
endmodule

// File: rtl/mdrop_wake_ctrl.sv
module mdrop_wake_ctrl
  import mdw_pkg::*;
#(
  parameter int unsigned LEN8 = IDLE_LEN_8,
  parameter int unsigned LEN9 = IDLE_LEN_9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic ctrl_wake_en_i,
  input  logic wake_sel_i,
  input  logic nine_bit_i,
  input  logic rx_irq_en_i,
  input  logic bit_stb_i,
  input  logic bit_val_i,
  input  logic char_done_i,
  input  logic char_msb_i,
  output logic standby_o,
  output logic rx_irq_en_o,
  output logic char_deliver_o
);
  wake_sel_e sel;
  logic      addr_mode;
  logic      idle_hit;
  logic      addr_hit;
  logic      standby;
  logic      enter;

  assign sel       = wake_sel_e'(wake_sel_i);
  assign addr_mode = (sel == WAKE_ADDR);
  assign enter     = ctrl_wr_i & ctrl_wake_en_i;

  mdw_idle_det #(.LEN8(LEN8), .LEN9(LEN9)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (enter),
    .nine_bit_i (nine_bit_i),
    .bit_stb_i  (bit_stb_i),
    .bit_val_i  (bit_val_i),
    .idle_hit_o (idle_hit)
  );

  mdw_char_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .standby_i   (standby),
    .addr_mode_i (addr_mode),
    .char_done_i (char_done_i),
    .char_msb_i  (char_msb_i),
    .addr_hit_o  (addr_hit),
    .deliver_o   (char_deliver_o)
  );

  mdw_standby_reg u_stby (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (ctrl_wr_i),
    .wdata_i     (ctrl_wake_en_i),
    .idle_hit_i  (idle_hit),
    .addr_hit_i  (addr_hit),
    .addr_mode_i (addr_mode),
    .standby_o   (standby)
  );

  assign standby_o   = standby;
  assign rx_irq_en_o = rx_irq_en_i & ~standby;

  p_irq_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !rx_irq_en_o);
  p_addr_mode_no_idle_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(standby_o) && !$past(ctrl_wr_i) && $past(addr_mode)) |-> char_deliver_o);
  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!standby_o && !char_deliver_o));
endmodule

// File: tb/mdrop_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdrop_wake_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 0, wv = 0, sel = 0, nine = 0, irq = 1;
  logic bs = 0, bv = 0, cd = 0, cm = 0;
  logic standby, irq_o, deliver;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic  s;
    logic  d;
    logic  i;
    string req;
  } exp_t;
  exp_t q[$];

  // reference state
  logic   m_stby = 0;
  logic   m_armed = 0;
  int     m_cnt = 0;

  always #2 clk = ~clk;

  mdrop_wake_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(wr), .ctrl_wake_en_i(wv),
    .wake_sel_i(sel), .nine_bit_i(nine), .rx_irq_en_i(irq),
    .bit_stb_i(bs), .bit_val_i(bv), .char_done_i(cd), .char_msb_i(cm),
    .standby_o(standby), .rx_irq_en_o(irq_o), .char_deliver_o(deliver)
  );

  task automatic check(input string req, input logic s, input logic d, input logic i);
    checks++;
    if (standby !== s || deliver !== d || irq_o !== i) begin
      fails++;
      $display("FAIL %s: standby/deliver/irq actual=%b%b%b expected=%b%b%b",
               req, standby, deliver, irq_o, s, d, i);
    end
  endtask

  // monitor: sample 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, e.s, e.d, e.i);
    end
  end

  task automatic step(input logic b_s, input logic b_v, input logic c_d,
                      input logic c_m, input logic w_r, input logic w_v,
                      input string req);
    int   thr;
    logic wake_idle, wake_addr, dlv, nxt;
    exp_t e;
    @(negedge clk);
    bs = b_s; bv = b_v; cd = c_d; cm = c_m; wr = w_r; wv = w_v;
    thr       = nine ? 11 : 10;
    wake_idle = m_stby && !sel && b_s && b_v && m_armed && !(w_r && w_v) &&
                (m_cnt + 1 >= thr);
    wake_addr = m_stby && sel && c_d && c_m;
    dlv       = c_d && (!m_stby || wake_addr);
    if (w_r)                         nxt = w_v;
    else if (wake_idle || wake_addr) nxt = 1'b0;
    else                             nxt = m_stby;
    if (w_r && w_v) begin
      m_cnt = 0; m_armed = 0;
    end else if (b_s) begin
      if (!b_v) begin m_cnt = 0; m_armed = 1; end
      else if (m_cnt < thr) m_cnt++;
    end
    m_stby = nxt;
    e.s = nxt; e.d = dlv; e.i = irq && !nxt; e.req = req;
    q.push_back(e);
  endtask

  task automatic ones(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      step(1, 1, 0, 0, 0, 0, req);
      step(0, 0, 0, 0, 0, 0, req);  // R7: non-strobe cycle with 0 on line
    end
  endtask

  task automatic idle_cyc(input string req);
    step(0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #5;
    check("R1", 0, 0, 1);  // in reset
    @(negedge clk); rst_n = 1;
    idle_cyc("R1");

    // R11: outside standby every char is delivered
    step(0, 0, 1, 0, 0, 0, "R11");
    step(0, 0, 1, 1, 0, 0, "R11");
    idle_cyc("R11");

    // R2 enter standby; R3 masking
    step(1, 1, 0, 0, 1, 1, "R2");
    irq = 0; idle_cyc("R3"); irq = 1; idle_cyc("R3");

    // R8: already-idle line does not wake
    ones(13, "R8");
    // R10: idle mode, MSB=1 char not delivered
    step(0, 0, 1, 1, 0, 0, "R10");
    // R6: zero restarts run
    step(1, 0, 0, 0, 0, 0, "R6");
    ones(5, "R6");
    step(1, 0, 0, 0, 0, 0, "R6");
    ones(9, "R4");       // nine ones: still standby
    ones(1, "R4");       // tenth one: wake
    idle_cyc("R4");

    // R5: 9-bit needs eleven
    nine = 1;
    step(0, 0, 0, 0, 1, 1, "R2");
    step(1, 0, 0, 0, 0, 0, "R5");
    ones(10, "R5");
    ones(1, "R5");
    nine = 0;

    // address mark mode
    sel = 1;
    step(0, 0, 0, 0, 1, 1, "R2");
    step(0, 0, 1, 0, 0, 0, "R10");
    step(1, 0, 0, 0, 0, 0, "R10");
    ones(12, "R10");
    step(0, 0, 1, 1, 0, 0, "R9");
    idle_cyc("R9");

    // write wins over wake condition
    step(0, 0, 0, 0, 1, 1, "R2");
    step(0, 0, 1, 1, 1, 1, "R2");
    idle_cyc("R2");
    // write 0 leaves standby
    step(0, 0, 0, 0, 1, 0, "R2");
    idle_cyc("R2");
    sel = 0;
    step(0, 0, 1, 0, 0, 0, "R11");
    idle_cyc("R11");

    wait (q.size() == 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule